// File: doc/BRIEF.md
# Multi-Stage Watchdog Timer with Write Lock

This block is a watchdog peripheral. Software writes and reads it through a small word-addressed register port. A prescaler divides the block clock into watchdog ticks. Those ticks drive a chain of four timeout stages that run one after another. Each stage has its own timeout value and its own expiry action: do nothing, raise the interrupt, request a core reset, or request a system reset. When stage 3 expires the chain wraps back to stage 0.

Every configuration write is refused until software writes a fixed 32-bit key to the lock register. This includes feeding the watchdog and clearing the interrupt. A feed sends the sequencer back to stage 0 and restarts its counters. The stage-0 timeout is scaled by a static 2-bit selector, which models a fuse-programmed setting.

The reset requests are single-clock pulses meant for an external reset controller. The interrupt is a level output meant for an interrupt controller.

Top module: `multi_stage_wdt`

## Requirements
- R1: After reset, `irq`, `core_rst_req` and `sys_rst_req` are low, the block is locked, and every register reads as zero.
- R2: While locked, a write to any address other than the lock register has no effect. This covers feed and interrupt clear. Writing 32'h50D83AA1 to the lock register unlocks the block, and writing any other value locks it. Bit 0 of the lock register reads 1 while unlocked.
- R3: Bit 0 of the control register is the run enable and reads back as written. While it is 0, no stage expires, and the sequencer is held at stage 0 with its tick and timeout counters at zero. Setting it again restarts timing from the beginning.
- R4: The stage-0 timeout is the programmed stage-0 value shifted left by (`delay_sel` + 1), counted in ticks.
- R5: One tick lasts P clock cycles, where P is the prescale value. P = 0 behaves as P = 1. With run enable set at clock edge E0, a stage-0 expiry takes effect at edge E0 + P·(T0 << (`delay_sel`+1)).
- R6: The stages run in order 0, 1, 2, 3 and then wrap to 0. Stages 1 to 3 each last their own programmed number of ticks. A stage whose action is off still times out and passes control to the next stage.
- R7: Stage i's action sits in control bits [2i+2:2i+1]. The encoding is 0 off, 1 raise interrupt, 2 core reset request, 3 system reset request. A reset request is a high pulse of exactly one clock cycle, starting at the edge on which the stage expires.
- R8: The interrupt status bit is set by an expiry whose action is "raise interrupt". It stays set until a write to the interrupt register with bit 1 = 1 clears it. A set in the same cycle wins over the clear. `irq` equals status AND interrupt enable. The enable is bit 0 of the interrupt register, and the status reads back in bit 2.
- R9: An accepted write of any value to the feed register returns the sequencer to stage 0 and restarts both the tick counter and the timeout counter. The next stage-0 expiry therefore comes a full stage-0 timeout after the feed edge.
- R10: The register addresses are: control 0, prescale 1, feed 2, lock 3, stage timeouts 0 to 3 at addresses 4 to 7, interrupt 8. The prescale and timeout values read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler base |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Combinational read data |
| delay_sel | input | 2 | Static stage-0 timeout scale selector |
| irq | output | 1 | Level timeout interrupt |
| core_rst_req | output | 1 | One-cycle core reset request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The checker assumes that `delay_sel` stays constant while the watchdog runs, so any stage-0 length it sees is one fixed limit. It also assumes that reset is asserted across at least one clock edge before activity starts. The bench changes `delay_sel` only while run enable is 0, and it always clears the control register before reprogramming a vector. Every write is driven as a single strobe between clock edges, so the lock, feed and clear effects are each tied to one known edge.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int NUM_STG = 4;
    localparam int STG_W   = $clog2(NUM_STG);

    typedef enum logic [1:0] {
        ACT_OFF  = 2'd0,
        ACT_IRQ  = 2'd1,
        ACT_CORE = 2'd2,
        ACT_SYS  = 2'd3
    } act_e;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h50D8_3AA1;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
    localparam logic [ADDR_W-1:0] A_FEED  = 4'd2;
    localparam logic [ADDR_W-1:0] A_LOCK  = 4'd3;
    localparam logic [ADDR_W-1:0] A_TMO0  = 4'd4;
    localparam logic [ADDR_W-1:0] A_INT   = 4'd8;
endpackage

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic                          irq_set,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          run_en,
    output logic [PRE_W-1:0]              presc,
    output logic [NUM_STG-1:0][CNT_W-1:0] tmo,
    output logic [NUM_STG-1:0][1:0]       act,
    output logic                          feed,
    output logic                          int_en,
    output logic                          irq_raw,
    output logic                          unlocked
);
    typedef struct packed {
        logic                          unl;
        logic                          en;
        logic [PRE_W-1:0]              presc;
        logic [NUM_STG-1:0][CNT_W-1:0] tmo;
        logic [NUM_STG-1:0][1:0]       act;
        logic                          ien;
        logic                          raw;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr_ok;
    logic  int_clr;
    logic  wr_is_tmo;
    logic  rd_is_tmo;

    assign wr_is_tmo = (wr_addr[ADDR_W-1:STG_W] == A_TMO0[ADDR_W-1:STG_W]);
    assign rd_is_tmo = (rd_addr[ADDR_W-1:STG_W] == A_TMO0[ADDR_W-1:STG_W]);

    always_comb begin
        r_d     = r_q;
        feed    = 1'b0;
        int_clr = 1'b0;
        wr_ok   = wr_en && r_q.unl;
        // the lock register is the only one open while locked
        if (wr_en && wr_addr == A_LOCK) begin
            r_d.unl = (wr_data == UNLOCK_KEY);
        end
        if (wr_ok) begin
            if (wr_addr == A_CTRL) begin
                r_d.en = wr_data[0];
                for (int i = 0; i < NUM_STG; i++) begin
                    r_d.act[i] = wr_data[1+2*i +: 2];
                end
            end
            if (wr_addr == A_PRESC) r_d.presc = wr_data[PRE_W-1:0];
            if (wr_addr == A_FEED)  feed = 1'b1;
            if (wr_is_tmo)          r_d.tmo[wr_addr[STG_W-1:0]] = wr_data[CNT_W-1:0];
            if (wr_addr == A_INT) begin
                r_d.ien = wr_data[0];
                int_clr = wr_data[1];
            end
        end
        // a fresh expiry outranks a simultaneous clear
        if (int_clr) r_d.raw = 1'b0;
        if (irq_set) r_d.raw = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL: begin
                rd_data[0] = r_q.en;
                for (int i = 0; i < NUM_STG; i++) begin
                    rd_data[1+2*i +: 2] = r_q.act[i];
                end
            end
            A_PRESC: rd_data[PRE_W-1:0] = r_q.presc;
            A_LOCK:  rd_data[0] = r_q.unl;
            A_INT: begin
                rd_data[0] = r_q.ien;
                rd_data[2] = r_q.raw;
            end
            default: begin
                if (rd_is_tmo) rd_data[CNT_W-1:0] = r_q.tmo[rd_addr[STG_W-1:0]];
            end
        endcase
    end

    assign run_en   = r_q.en;
    assign presc    = r_q.presc;
    assign tmo      = r_q.tmo;
    assign act      = r_q.act;
    assign int_en   = r_q.ien;
    assign irq_raw  = r_q.raw;
    assign unlocked = r_q.unl;
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             feed,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t             p_q, p_d;
    logic [PRE_W-1:0] last_cnt;

    always_comb begin
        // zero is treated as a divide by one
        last_cnt = (presc == '0) ? '0 : presc - PRE_W'(1);
        tick     = run_en && (p_q.cnt >= last_cnt);
        p_d      = p_q;
        if (!run_en || feed || tick) p_d.cnt = '0;
        else                         p_d.cnt = p_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/wdt_stage_seq.sv
`timescale 1ns/1ps
module wdt_stage_seq
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run_en,
    input  logic                          feed,
    input  logic                          tick,
    input  logic [1:0]                    delay_sel,
    input  logic [NUM_STG-1:0][CNT_W-1:0] tmo,
    input  logic [NUM_STG-1:0][1:0]       act,
    output logic [STG_W-1:0]              stage,
    output logic                          expire,
    output logic                          irq_set,
    output logic                          core_rst_req,
    output logic                          sys_rst_req
);
    localparam int SHIFT_MAX = 4;
    localparam int LIM_W     = CNT_W + SHIFT_MAX;

    typedef struct packed {
        logic [STG_W-1:0] stage;
        logic [LIM_W-1:0] cnt;
        logic             core;
        logic             sys;
    } seq_t;

    seq_t             s_q, s_d;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] cnt_inc;
    logic [1:0]       cur_act;

    always_comb begin
        if (s_q.stage == '0) limit = LIM_W'(tmo[0]) << ({1'b0, delay_sel} + 3'd1);
        else                 limit = LIM_W'(tmo[s_q.stage]);
        cnt_inc = s_q.cnt + LIM_W'(1);
        cur_act = act[s_q.stage];
        expire  = run_en && !feed && tick && (cnt_inc >= limit);
        irq_set = expire && (cur_act == ACT_IRQ);

        s_d      = s_q;
        s_d.core = expire && (cur_act == ACT_CORE);
        s_d.sys  = expire && (cur_act == ACT_SYS);
        if (!run_en || feed) begin
            s_d.stage = '0;
            s_d.cnt   = '0;
        end else if (expire) begin
            s_d.stage = s_q.stage + STG_W'(1);
            s_d.cnt   = '0;
        end else if (tick) begin
            s_d.cnt   = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stage        = s_q.stage;
    assign core_rst_req = s_q.core;
    assign sys_rst_req  = s_q.sys;
endmodule

// File: rtl/multi_stage_wdt.sv
`timescale 1ns/1ps
module multi_stage_wdt
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        delay_sel,
    output logic              irq,
    output logic              core_rst_req,
    output logic              sys_rst_req
);
    logic                          run_en;
    logic [PRE_W-1:0]              presc;
    logic [NUM_STG-1:0][CNT_W-1:0] tmo;
    logic [NUM_STG-1:0][1:0]       act;
    logic                          feed;
    logic                          int_en;
    logic                          irq_raw;
    logic                          unlocked;
    logic                          tick;
    logic [STG_W-1:0]              stage;
    logic                          expire;
    logic                          irq_set;

    wdt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .irq_set(irq_set),
        .rd_data(rd_data), .run_en(run_en), .presc(presc), .tmo(tmo),
        .act(act), .feed(feed), .int_en(int_en), .irq_raw(irq_raw),
        .unlocked(unlocked)
    );

    wdt_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .feed(feed),
        .presc(presc), .tick(tick)
    );

    wdt_stage_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .feed(feed), .tick(tick),
        .delay_sel(delay_sel), .tmo(tmo), .act(act), .stage(stage),
        .expire(expire), .irq_set(irq_set), .core_rst_req(core_rst_req),
        .sys_rst_req(sys_rst_req)
    );

    assign irq = int_en & irq_raw;
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic       unlocked,
    input logic [1:0] stage,
    input logic       expire,
    input logic       feed,
    input logic       irq_set,
    input logic       irq_raw,
    input logic       core_rst_req,
    input logic       sys_rst_req
);
    AST_LOCK_HOLDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(cfg_en)); // R2
    AST_STOP_CLEARS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (stage == 2'd0)); // R3
    AST_STAGE_MOVES_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stage) |-> $past(expire || feed || !cfg_en)); // R6
    AST_CORE_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_req |-> $past(expire)); // R7
    AST_SYS_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(expire)); // R7
    AST_ONE_RESET_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rst_req && sys_rst_req)); // R7
    AST_RAW_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_raw) |-> $past(irq_set)); // R8
    AST_FEED_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        feed |=> (stage == 2'd0)); // R9
endmodule

bind multi_stage_wdt wdt_checker u_wdt_checker (
    .clk(clk), .rst_n(rst_n), .cfg_en(run_en), .unlocked(unlocked),
    .stage(stage), .expire(expire), .feed(feed), .irq_set(irq_set),
    .irq_raw(irq_raw), .core_rst_req(core_rst_req), .sys_rst_req(sys_rst_req)
);

// File: tb/multi_stage_wdt_bench.sv
`timescale 1ns/1ps
module multi_stage_wdt_bench;
    import wdt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  delay_sel = '0;
    logic        irq, core_rst_req, sys_rst_req;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    multi_stage_wdt u_multi_stage_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .delay_sel(delay_sel), .irq(irq), .core_rst_req(core_rst_req),
        .sys_rst_req(sys_rst_req)
    );

    localparam int N_VEC = 5;
    localparam int V_PRE [N_VEC] = '{1, 2, 0, 3, 1};
    localparam int V_T0  [N_VEC] = '{3, 2, 5, 1, 2};
    localparam int V_DS  [N_VEC] = '{0, 1, 0, 2, 3};
    localparam int V_ACT [N_VEC] = '{1, 2, 3, 1, 2};
    localparam int V_EXP [N_VEC] = '{6, 16, 10, 24, 32};

    task automatic check(input bit ok, input string req, input longint act_v, input longint exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [1:0] a0, input logic [1:0] a1,
                                            input logic [1:0] a2, input logic [1:0] a3);
        return {23'b0, a3, a2, a1, a0, 1'b0};
    endfunction

    // counts edges after the last write until the wanted output is seen, -1 if never
    task automatic run_until(input int kind, input int maxc, output int cnt);
        cnt = -1;
        for (int k = 1; k <= maxc; k++) begin
            @(posedge clk);
            #1;
            if ((kind == 1 && irq) || (kind == 2 && core_rst_req) || (kind == 3 && sys_rst_req)) begin
                cnt = k;
                break;
            end
        end
    endtask

    task automatic setup(input int pre, input int t0, input int t1, input int t2,
                         input int t3, input int ds);
        wr(A_LOCK, UNLOCK_KEY);
        wr(A_CTRL, 32'd0);
        wr(A_INT, 32'd3);
        wr(A_PRESC, pre);
        wr(A_TMO0, t0);
        wr(A_TMO0 + 4'd1, t1);
        wr(A_TMO0 + 4'd2, t2);
        wr(A_TMO0 + 4'd3, t3);
        delay_sel = 2'(ds);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check(!irq && !core_rst_req && !sys_rst_req, "R1 outputs", {irq, core_rst_req, sys_rst_req}, 0);
        rd(A_CTRL, v);  check(v == 0, "R1 ctrl", v, 0);
        rd(A_LOCK, v);  check(v == 0, "R1 lock", v, 0);
        rd(A_INT, v);   check(v == 0, "R1 int", v, 0);
        rd(A_PRESC, v); check(v == 0, "R1 presc", v, 0);

        // R2 lock behaviour
        wr(A_CTRL, 32'd1);
        rd(A_CTRL, v);  check(v == 0, "R2 locked ctrl write", v, 0);
        wr(A_LOCK, 32'h1234);
        rd(A_LOCK, v);  check(v == 0, "R2 wrong key", v, 0);
        wr(A_LOCK, UNLOCK_KEY);
        rd(A_LOCK, v);  check(v == 1, "R2 key unlocks", v, 1);
        wr(A_PRESC, 32'd7);
        rd(A_PRESC, v); check(v == 7, "R10 presc readback", v, 7);
        wr(A_TMO0 + 4'd2, 32'd77);
        rd(A_TMO0 + 4'd2, v); check(v == 77, "R10 tmo2 readback", v, 77);
        wr(A_LOCK, 32'd0);
        rd(A_LOCK, v);  check(v == 0, "R2 relock", v, 0);
        wr(A_PRESC, 32'd9);
        rd(A_PRESC, v); check(v == 7, "R2 locked presc write", v, 7);

        // R4 R5 R7 vector table
        for (int i = 0; i < N_VEC; i++) begin
            setup(V_PRE[i], V_T0[i], 1000, 1000, 1000, V_DS[i]);
            wr(A_CTRL, mk_ctrl(2'(V_ACT[i]), ACT_OFF, ACT_OFF, ACT_OFF) | 32'd1);
            run_until(V_ACT[i], 200, n);
            check(n == V_EXP[i], "R4/R5/R7 vector", n, V_EXP[i]);
        end

        // R9 feed postpones expiry
        setup(1, 5, 1000, 1000, 1000, 0);
        wr(A_CTRL, mk_ctrl(ACT_IRQ, ACT_OFF, ACT_OFF, ACT_OFF) | 32'd1);
        repeat (6) @(posedge clk);
        #1 check(!irq, "R9 no irq before feed", irq, 0);
        wr(A_FEED, 32'd0);
        run_until(1, 100, n);
        check(n == 10, "R9 feed restart", n, 10);

        // R2 R9 locked feed and locked clear ignored
        setup(1, 5, 1000, 1000, 1000, 0);
        wr(A_CTRL, mk_ctrl(ACT_IRQ, ACT_OFF, ACT_OFF, ACT_OFF) | 32'd1);
        repeat (6) @(posedge clk);
        wr(A_LOCK, 32'd0);
        wr(A_FEED, 32'd0);
        run_until(1, 100, n);
        check(n == 2, "R9 locked feed ignored", n, 2);
        wr(A_INT, 32'd3);
        check(irq, "R2 locked clear ignored", irq, 1);
        wr(A_LOCK, UNLOCK_KEY);
        wr(A_INT, 32'd3);
        check(!irq, "R8 clear drops irq", irq, 0);

        // R6 off stage still advances
        setup(1, 1, 3, 1000, 1000, 0);
        wr(A_CTRL, mk_ctrl(ACT_OFF, ACT_IRQ, ACT_OFF, ACT_OFF) | 32'd1);
        run_until(1, 100, n);
        check(n == 5, "R6 chain 0->1", n, 5);

        // R6 R7 wrap and one-cycle pulse
        setup(1, 1, 1, 1, 1, 0);
        wr(A_CTRL, mk_ctrl(ACT_OFF, ACT_OFF, ACT_OFF, ACT_CORE) | 32'd1);
        run_until(2, 100, n);
        check(n == 5, "R6 reach stage 3", n, 5);
        @(posedge clk);
        #1 check(!core_rst_req, "R7 pulse width", core_rst_req, 0);
        run_until(2, 100, n);
        check(n == 4, "R6 wrap to stage 0", n, 4);

        // R3 stop and restart
        setup(1, 5, 1000, 1000, 1000, 0);
        wr(A_CTRL, mk_ctrl(ACT_IRQ, ACT_OFF, ACT_OFF, ACT_OFF) | 32'd1);
        repeat (4) @(posedge clk);
        wr(A_CTRL, mk_ctrl(ACT_IRQ, ACT_OFF, ACT_OFF, ACT_OFF));
        run_until(1, 30, n);
        check(n == -1, "R3 stopped no expiry", n, -1);
        rd(A_CTRL, v);  check(v[0] == 1'b0, "R3 enable readback", v[0], 0);
        wr(A_CTRL, mk_ctrl(ACT_IRQ, ACT_OFF, ACT_OFF, ACT_OFF) | 32'd1);
        run_until(1, 100, n);
        check(n == 10, "R3 restart from zero", n, 10);

        // R8 enable gating and status
        setup(1, 3, 1000, 1000, 1000, 0);
        wr(A_INT, 32'd0);
        wr(A_CTRL, mk_ctrl(ACT_IRQ, ACT_OFF, ACT_OFF, ACT_OFF) | 32'd1);
        run_until(1, 20, n);
        check(n == -1, "R8 masked irq", n, -1);
        rd(A_INT, v);   check(v == 4, "R8 raw status", v, 4);
        wr(A_INT, 32'd1);
        check(irq, "R8 unmask raises irq", irq, 1);
        wr(A_INT, 32'd3);
        check(!irq, "R8 clear", irq, 0);
        rd(A_INT, v);   check(v == 1, "R8 status cleared", v, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule